// File: doc/BRIEF.md
# Opcode-Selected 16-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a 16-bit datapath. Two operands and a 4-bit operation code enter. A 16-bit result and a single carry/borrow flag leave, with no clock and no storage. Every function unit evaluates at the same time. An output multiplexer steered by the operation code forwards one result.

The hardware is shared wherever it can be. One carry-select adder does addition, increment (second addend forced to one) and two's complement negation (operand inverted, then incremented). A second carry-select instance, fed with the inverted subtrahend and a carry-in of one, does subtraction and decrement (subtrahend forced to one). An 8x8 shift-add multiplier takes the low byte of each operand and returns the full 16-bit product. The bitwise functions come from a small logic slice.

Top module: `alu16_core`

## Requirements
- R1: Opcode 4'b0001 gives res_o = (A + B) mod 2^16 and cb_o = the carry out of bit 15.
- R2: Opcode 4'b0011 gives res_o = (A - B) mod 2^16 and cb_o = 1 exactly when A < B, both taken as unsigned.
- R3: Opcode 4'b0010 gives res_o = A[7:0] * B[7:0] as an unsigned 16-bit product; A[15:8] and B[15:8] have no effect and cb_o = 0.
- R4: Opcode 4'b0100 gives the bitwise AND of A and B, and 4'b0101 gives the bitwise OR; cb_o = 0 for both.
- R5: Opcode 4'b0110 gives the bitwise NAND of A and B, and 4'b0111 gives the bitwise NOR; cb_o = 0 for both.
- R6: Opcode 4'b1000 gives the bitwise XOR of A and B, with cb_o = 0.
- R7: Opcode 4'b1001 gives res_o = (A + 1) mod 2^16 and cb_o = the carry out, so A = 16'hFFFF yields 0 with cb_o = 1.
- R8: Opcode 4'b1010 gives res_o = (A - 1) mod 2^16 and cb_o = the borrow, so A = 0 yields 16'hFFFF with cb_o = 1.
- R9: Opcode 4'b1011 gives res_o = ~A, with cb_o = 0.
- R10: Opcode 4'b1100 gives res_o = (~A + 1) mod 2^16, with cb_o = 0 in every case, including A = 0.
- R11: Opcodes 4'b0000 and 4'b1101 to 4'b1111 give res_o = 0 and cb_o = 0.
- R12: For the unary opcodes (increment, decrement, NOT, negate), operand B has no effect on res_o or cb_o.
- R13: res_o and cb_o depend only on the present inputs. They settle within the same cycle the inputs change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand; the only operand of the unary functions |
| opb_i | input | 16 | Second operand; only its low byte is used by multiply |
| op_i | input | 4 | Operation code selecting the forwarded result |
| res_o | output | 16 | Selected result |
| cb_o | output | 1 | Carry for add and increment, borrow for subtract and decrement, zero otherwise |

## Verification
The embedded immediate assertions assume the inputs carry known 0/1 values. Each one is guarded so that it is skipped while any operand or the opcode is unknown. The bench drives every input to a defined value before the first sample, changes inputs only just after a rising clock edge and samples at the falling edge, so the checks never see a half-updated input set. Operand values cover the carry and borrow boundaries (all-ones, zero, the sign bit), non-zero upper bytes for multiply, and a pseudo-random sweep over every opcode, including the unused ones.

// File: rtl/alu16_pkg.sv
// Package alu16_pkg
// Shared widths and the operation code map of the 16-bit ALU.
// Assumes: the opcode values are fixed by the instruction decoder outside.
package alu16_pkg;

    localparam int DATA_W = 16;
    localparam int MUL_W  = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 4'h0,
        OP_ADD  = 4'h1,
        OP_MUL  = 4'h2,
        OP_SUB  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_NAND = 4'h6,
        OP_NOR  = 4'h7,
        OP_XOR  = 4'h8,
        OP_INC  = 4'h9,
        OP_DEC  = 4'hA,
        OP_NOT  = 4'hB,
        OP_NEG  = 4'hC
    } alu_op_e;

endpackage

// File: rtl/csel_adder.sv
// Module csel_adder
// Carry-select adder. The word is cut into blocks of BLK bits. Each block
// ripples two sums, one for carry-in 0 and one for carry-in 1, and the
// carry arriving from the block below picks one of them.
// Assumes: W is a whole multiple of BLK.
module csel_adder #(
    parameter int W   = 16,
    parameter int BLK = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int NBLK = W / BLK;

    logic [NBLK:0] blk_carry;

    assign blk_carry[0] = cin_i;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic [BLK-1:0] sum_c0;
        logic [BLK-1:0] sum_c1;
        logic           co_c0;
        logic           co_c1;

        // Ripple both speculative sums of this block.
        always_comb begin : ripple_pair
            logic k0;
            logic k1;
            k0 = 1'b0;
            k1 = 1'b1;
            for (int i = 0; i < BLK; i++) begin
                sum_c0[i] = a_i[g*BLK+i] ^ b_i[g*BLK+i] ^ k0;
                sum_c1[i] = a_i[g*BLK+i] ^ b_i[g*BLK+i] ^ k1;
                k0 = (a_i[g*BLK+i] & b_i[g*BLK+i]) | (k0 & (a_i[g*BLK+i] ^ b_i[g*BLK+i]));
                k1 = (a_i[g*BLK+i] & b_i[g*BLK+i]) | (k1 & (a_i[g*BLK+i] ^ b_i[g*BLK+i]));
            end
            co_c0 = k0;
            co_c1 = k1;
        end

        assign sum_o[g*BLK +: BLK] = blk_carry[g] ? sum_c1 : sum_c0;
        assign blk_carry[g+1]      = blk_carry[g] ? co_c1  : co_c0;
    end

    assign cout_o = blk_carry[NBLK];

    // Check the selected block sums against plain binary addition.
    always_comb begin : chk_sum
        if (!$isunknown({a_i, b_i, cin_i})) begin
            AST_CSEL_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
                else $error("carry-select sum mismatch"); // R1
        end
    end

endmodule

// File: rtl/shift_add_mul.sv
// Module shift_add_mul
// Unsigned IN_W x IN_W multiplier built from shifted partial products
// summed one row at a time; the product is 2*IN_W bits wide.
// Assumes: both operands are unsigned.
module shift_add_mul #(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]   a_i,
    input  logic [IN_W-1:0]   b_i,
    output logic [2*IN_W-1:0] prod_o
);

    localparam int OUT_W = 2 * IN_W;

    // Accumulate one shifted copy of a_i for each set bit of b_i.
    always_comb begin : accum_rows
        logic [OUT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (b_i[i]) begin
                acc = acc + ({{IN_W{1'b0}}, a_i} << i);
            end
        end
        prod_o = acc;
    end

    // Compare the row sum with an arithmetic product.
    always_comb begin : chk_prod
        if (!$isunknown({a_i, b_i})) begin
            AST_MUL_PRODUCT: assert (prod_o == OUT_W'({{IN_W{1'b0}}, a_i} * {{IN_W{1'b0}}, b_i}))
                else $error("multiplier product mismatch"); // R3
        end
    end

endmodule

// File: rtl/bit_logic.sv
// Module bit_logic
// Bitwise logic slice: AND, OR, NAND, NOR, XOR of two words and NOT of
// the first. NAND and NOR use the De Morgan forms so they form separate
// logic from AND and OR.
// Assumes: nothing beyond equal operand widths.
module bit_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] nand_o,
    output logic [W-1:0] nor_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] not_o
);

    assign and_o  = a_i & b_i;
    assign or_o   = a_i | b_i;
    assign nand_o = ~a_i | ~b_i;
    assign nor_o  = ~a_i & ~b_i;
    assign xor_o  = (a_i | b_i) & ~(a_i & b_i);
    assign not_o  = ~a_i;

    // Tie the inverted forms to their positive partners.
    always_comb begin : chk_inverse
        if (!$isunknown({a_i, b_i})) begin
            AST_NAND_INVERSE: assert (nand_o == ~and_o) else $error("nand mismatch"); // R5
            AST_NOR_INVERSE: assert (nor_o == ~or_o) else $error("nor mismatch"); // R5
            AST_XOR_PARTS: assert (xor_o == (or_o & nand_o)) else $error("xor mismatch"); // R6
        end
    end

endmodule

// File: rtl/alu16_core.sv
// Module alu16_core
// Combinational 16-bit ALU. One adder serves add, increment and negate;
// one subtractor serves subtract and decrement; a byte multiplier and a
// logic slice finish the set. The opcode steers the operand muxes and the
// output mux.
// Assumes: inputs are steady for the cycle in which res_o is consumed.
module alu16_core #(
    parameter int DATA_W = alu16_pkg::DATA_W,
    parameter int MUL_W  = alu16_pkg::MUL_W,
    parameter int BLK    = 4
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [3:0]        op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cb_o
);
    import alu16_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [DATA_W-1:0] add_a, add_b, add_sum;
    logic              add_cout;
    logic [DATA_W-1:0] sub_b, sub_diff;
    logic              sub_cout;
    logic [2*MUL_W-1:0] mul_prod;
    logic [DATA_W-1:0] l_and, l_or, l_nand, l_nor, l_xor, l_not;

    // Adder operands: invert A for negate, force B to one for unary use.
    always_comb begin : adder_operands
        add_a = (op == OP_NEG) ? ~opa_i : opa_i;
        add_b = (op == OP_ADD) ? opb_i : ONE;
    end

    // Subtrahend: force to one for decrement.
    assign sub_b = (op == OP_DEC) ? ONE : opb_i;

    csel_adder #(.W(DATA_W), .BLK(BLK)) adder_i (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (1'b0),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    csel_adder #(.W(DATA_W), .BLK(BLK)) subtr_i (
        .a_i    (opa_i),
        .b_i    (~sub_b),
        .cin_i  (1'b1),
        .sum_o  (sub_diff),
        .cout_o (sub_cout)
    );

    shift_add_mul #(.IN_W(MUL_W)) mul_i (
        .a_i    (opa_i[MUL_W-1:0]),
        .b_i    (opb_i[MUL_W-1:0]),
        .prod_o (mul_prod)
    );

    bit_logic #(.W(DATA_W)) logic_i (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .and_o  (l_and),
        .or_o   (l_or),
        .nand_o (l_nand),
        .nor_o  (l_nor),
        .xor_o  (l_xor),
        .not_o  (l_not)
    );

    // Output multiplexer: forward one unit's result and its flag.
    always_comb begin : result_mux
        res_o = '0;
        cb_o  = 1'b0;
        case (op)
            OP_ADD:  begin res_o = add_sum;  cb_o = add_cout;  end
            OP_INC:  begin res_o = add_sum;  cb_o = add_cout;  end
            OP_NEG:  res_o = add_sum;
            OP_SUB:  begin res_o = sub_diff; cb_o = ~sub_cout; end
            OP_DEC:  begin res_o = sub_diff; cb_o = ~sub_cout; end
            OP_MUL:  res_o = DATA_W'(mul_prod);
            OP_AND:  res_o = l_and;
            OP_OR:   res_o = l_or;
            OP_NAND: res_o = l_nand;
            OP_NOR:  res_o = l_nor;
            OP_XOR:  res_o = l_xor;
            OP_NOT:  res_o = l_not;
            default: begin res_o = '0; cb_o = 1'b0; end
        endcase
    end

    // Port-level checks on the selected result and flag.
    always_comb begin : chk_ports
        if (!$isunknown({opa_i, opb_i, op_i})) begin
            if (op_i == 4'h0 || op_i > 4'hC) begin
                AST_UNUSED_ZERO: assert (res_o == '0 && !cb_o) else $error("unused opcode not zero"); // R11
            end
            if (op_i == 4'h3) begin
                AST_SUB_BORROW: assert (cb_o == (opa_i < opb_i)) else $error("borrow flag wrong"); // R2
            end
            if (op_i == 4'hA) begin
                AST_DEC_WRAP: assert (cb_o == (opa_i == '0)) else $error("decrement borrow wrong"); // R8
            end
            if (op_i == 4'h9) begin
                AST_INC_WRAP: assert (cb_o == (opa_i == '1) && (res_o == '0) == (opa_i == '1))
                    else $error("increment wrap wrong"); // R7
            end
            if (op_i == 4'hC) begin
                AST_NEG_CANCEL: assert (DATA_W'(res_o + opa_i) == '0 && !cb_o) else $error("negate wrong"); // R10
            end
            if (op_i == 4'hB) begin
                AST_NOT_FLAG: assert (!cb_o && (res_o ^ opa_i) == '1) else $error("not wrong"); // R9
            end
        end
    end

endmodule

// File: tb/alu16_core_tb.sv
`timescale 1ns/1ps
// Self-checking bench for alu16_core: a vector table, then directed and
// swept tests with expected values from an independent model.
module alu16_core_tb_top;

    logic        clk = 1'b0;
    logic [15:0] opa, opb;
    logic [3:0]  op;
    logic [15:0] res;
    logic        cb;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    alu16_core dut_i (
        .opa_i (opa),
        .opb_i (opb),
        .op_i  (op),
        .res_o (res),
        .cb_o  (cb)
    );

    // Fields: opcode, A, B, expected result, expected flag.
    localparam int NV = 24;
    localparam logic [52:0] VEC [NV] = '{
        {4'h1, 16'h1234, 16'h1111, 16'h2345, 1'b0},
        {4'h1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},
        {4'h1, 16'h8000, 16'h8000, 16'h0000, 1'b1},
        {4'h3, 16'h0005, 16'h0003, 16'h0002, 1'b0},
        {4'h3, 16'h0003, 16'h0005, 16'hFFFE, 1'b1},
        {4'h3, 16'h1234, 16'h1234, 16'h0000, 1'b0},
        {4'h2, 16'h00FF, 16'h00FF, 16'hFE01, 1'b0},
        {4'h2, 16'hAB12, 16'hCD34, 16'h03A8, 1'b0},
        {4'h4, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0},
        {4'h5, 16'hF0F0, 16'h0F0F, 16'hFFFF, 1'b0},
        {4'h6, 16'hF0F0, 16'hFF00, 16'h0FFF, 1'b0},
        {4'h7, 16'hF0F0, 16'hFF00, 16'h000F, 1'b0},
        {4'h8, 16'hAAAA, 16'hFFFF, 16'h5555, 1'b0},
        {4'h9, 16'hFFFF, 16'h1234, 16'h0000, 1'b1},
        {4'h9, 16'h00FF, 16'h0000, 16'h0100, 1'b0},
        {4'hA, 16'h0000, 16'h5555, 16'hFFFF, 1'b1},
        {4'hA, 16'h0100, 16'h0000, 16'h00FF, 1'b0},
        {4'hB, 16'h1234, 16'hFFFF, 16'hEDCB, 1'b0},
        {4'hC, 16'h0001, 16'h0000, 16'hFFFF, 1'b0},
        {4'hC, 16'h0000, 16'h0000, 16'h0000, 1'b0},
        {4'hC, 16'h8000, 16'h0000, 16'h8000, 1'b0},
        {4'h0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0},
        {4'hD, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0},
        {4'hF, 16'h1234, 16'h5678, 16'h0000, 1'b0}
    };

    // Requirement tag of each opcode.
    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'h1: return "R1";
            4'h3: return "R2";
            4'h2: return "R3";
            4'h4, 4'h5: return "R4";
            4'h6, 4'h7: return "R5";
            4'h8: return "R6";
            4'h9: return "R7";
            4'hA: return "R8";
            4'hB: return "R9";
            4'hC: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Independent reference model written from the requirements.
    task automatic model(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] r, output logic f);
        logic [16:0] w;
        r = 16'h0;
        f = 1'b0;
        case (o)
            4'h1: begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; f = w[16]; end
            4'h3: begin r = a - b; f = (a < b); end
            4'h2: r = {8'h00, a[7:0]} * {8'h00, b[7:0]};
            4'h4: r = a & b;
            4'h5: r = a | b;
            4'h6: r = ~(a & b);
            4'h7: r = ~(a | b);
            4'h8: r = a ^ b;
            4'h9: begin r = a + 16'h1; f = (a == 16'hFFFF); end
            4'hA: begin r = a - 16'h1; f = (a == 16'h0000); end
            4'hB: r = ~a;
            4'hC: r = 16'h0 - a;
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input logic [15:0] er, input logic ef);
        checks++;
        if (res !== er || cb !== ef) begin
            errors++;
            $display("FAIL %s op=%h a=%h b=%h: actual res=%h cb=%b expected res=%h cb=%b",
                     tag, op, opa, opb, res, cb, er, ef);
        end
    endtask

    // Drive just after a rising edge, sample at the following falling edge.
    task automatic apply(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b);
        @(posedge clk);
        #0.5;
        op  = o;
        opa = a;
        opb = b;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] er, r_first;
        logic        ef, f_first;
        logic [15:0] sa, sb;
        op  = 4'h0;
        opa = 16'h0;
        opb = 16'h0;
        @(negedge clk);
        check("R11", 16'h0, 1'b0); // quiet state with the idle opcode

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][52:49], VEC[i][48:33], VEC[i][32:17]);
            check(tag_of(VEC[i][52:49]), VEC[i][16:1], VEC[i][0]);
        end

        // R13: result follows an input change within the same cycle, no edge needed.
        @(posedge clk);
        #0.5;
        op = 4'h1; opa = 16'h0010; opb = 16'h0020;
        #0.5;
        check("R13", 16'h0030, 1'b0);
        opb = 16'hFFF0;
        #0.5;
        check("R13", 16'h0000, 1'b1);

        // R12: B is ignored by the unary opcodes.
        for (int u = 9; u <= 12; u++) begin
            apply(4'(u), 16'h7FFF, 16'h0000);
            r_first = res;
            f_first = cb;
            apply(4'(u), 16'h7FFF, 16'hFFFF);
            check("R12", r_first, f_first);
        end

        // R3: upper bytes of both operands are ignored by multiply.
        apply(4'h2, 16'hFF07, 16'h0009);
        check("R3", 16'h003F, 1'b0);

        // Swept operands over every opcode, compared with the model.
        sa = 16'h1D2B;
        sb = 16'hC3A5;
        for (int n = 0; n < 300; n++) begin
            sa = sa * 16'd25173 + 16'd13849;
            sb = {sb[14:0], sb[15] ^ sb[13] ^ sb[12] ^ sb[10]};
            for (int o = 0; o < 16; o++) begin
                apply(4'(o), sa, sb);
                model(4'(o), sa, sb, er, ef);
                check(tag_of(4'(o)), er, ef);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check that still reaches the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R13: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule